// File: doc/BRIEF.md
# Role Value Support Accumulator

This block decides whether one candidate role value stays in play after binary constraint checking. The arc matrices are never built. An external constraint evaluator pairs the role value under test with each partner role value in turn, and streams one pass/fail result per pair into this block. The results arrive grouped by neighbouring word node, and each result carries markers for the first result of a group, the last result of a group, and the last group for the role value under test.

Inside a group, a one-shot OR records whether any partner from that neighbour is compatible. At the end of the group, that OR is folded into a running AND over all neighbours. After the last group, the block issues a keep or drop decision. An all-zero group stands for an empty matrix row or column, so it always forces a drop.

The block also counts drops over a sweep. When the sweep ends, it reports whether the sweep removed nothing. A filtering controller can then repeat sweeps until it sees that converged report.

Top module: `rv_support_acc`

## Requirements
- R1: After synchronous reset, `dec_valid`, `dec_keep`, `sweep_done`, `converged` and `drop_count` are all zero.
- R2: A valid result with `res_first`=1 starts the group OR from its own pass bit and discards the previous OR. Once the OR is high, it stays high until the next group start.
- R3: The neighbour AND presets to 1 at the start of every role value. It absorbs the group OR on the cycle a valid result with `res_grp_last`=1 is accepted.
- R4: One cycle after a valid result with both `res_grp_last`=1 and `res_rv_last`=1 is accepted, `dec_valid` is high for exactly one cycle. At that point `dec_keep` equals the AND of all group ORs (1 = keep, 0 = drop).
- R5: A group whose accepted results are all fail forces a drop decision, whatever the other groups contain.
- R6: A `rv_bare` pulse, meaning a role value with no neighbour groups, produces a keep decision on the next cycle.
- R7: `drop_count` clears on `sweep_start`. It rises by one on the cycle after each drop decision, and it saturates at its maximum value.
- R8: A `sweep_end` pulse gives a one-cycle `sweep_done` on the next cycle. At that point `converged` is 1 if `drop_count` was zero, and 0 otherwise. `sweep_start` clears `converged`.
- R9: Results presented with `res_valid`=0 have no effect on either accumulator or on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Result beat is present |
| res_pass | input | 1 | Pair is compatible |
| res_first | input | 1 | First result of a neighbour group |
| res_grp_last | input | 1 | Last result of a neighbour group |
| res_rv_last | input | 1 | Group is the final one for this role value |
| rv_bare | input | 1 | Role value has no neighbours |
| sweep_start | input | 1 | Begin a filtering sweep |
| sweep_end | input | 1 | Close the current sweep |
| dec_valid | output | 1 | Decision strobe |
| dec_keep | output | 1 | 1 keep, 0 drop |
| drop_count | output | CNT_W | Drops in the current sweep |
| sweep_done | output | 1 | Sweep close strobe |
| converged | output | 1 | Last closed sweep dropped nothing |

## Verification
The assertions take several things for granted about the inputs:
- `res_rv_last` is only raised together with `res_grp_last`.
- `rv_bare` never coincides with a valid result.
- `sweep_end` is not pulsed in the same cycle as a decision or the count update that follows it.

The directed stimulus honours all three. It inserts idle cycles between a role value's last beat and any sweep control. It also keeps beats with `res_valid` low, and with random-looking marker bits, inside groups only, so that they test R9 without breaking the framing.

// File: rtl/rvs_pkg.sv
package rvs_pkg;
  typedef struct packed {
    logic pass;
    logic first;
    logic grp_last;
    logic rv_last;
  } beat_t;
endpackage

// File: rtl/rvs_group_or.sv
module rvs_group_or
  import rvs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  valid,
  input  beat_t beat,
  output logic  or_now
);
  logic or_q;

  assign or_now = (beat.first ? 1'b0 : or_q) | beat.pass;

  always_ff @(posedge clk) begin
    if (rst) or_q <= 1'b0;
    else if (valid) or_q <= or_now;
  end

  // R2: sticky until the next group start
  a_r2_or_sticky: assert property (@(posedge clk) disable iff (rst)
    (or_q && !(valid && beat.first)) |=> or_q);
  // R9: an invalid beat leaves the OR untouched
  a_r9_or_hold: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(or_q));
endmodule

// File: rtl/rvs_rv_and.sv
module rvs_rv_and
  import rvs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  valid,
  input  beat_t beat,
  input  logic  or_now,
  input  logic  bare,
  output logic  dec_valid,
  output logic  dec_keep
);
  logic and_q;
  logic and_now;

  assign and_now = and_q & or_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      and_q     <= 1'b1;
      dec_valid <= 1'b0;
      dec_keep  <= 1'b0;
    end else begin
      dec_valid <= 1'b0;
      if (bare) begin
        dec_valid <= 1'b1;
        dec_keep  <= 1'b1;
        and_q     <= 1'b1;
      end else if (valid && beat.grp_last) begin
        if (beat.rv_last) begin
          dec_valid <= 1'b1;
          dec_keep  <= and_now;
          and_q     <= 1'b1;
        end else begin
          and_q <= and_now;
        end
      end
    end
  end

  // R5: a failed group clears the AND for the rest of the role value
  a_r5_zero_group: assert property (@(posedge clk) disable iff (rst)
    (valid && !bare && beat.grp_last && !beat.rv_last && !or_now) |=> !and_q);
  // R4/R5: a failed final group yields a drop strobe
  a_r4_drop_dec: assert property (@(posedge clk) disable iff (rst)
    (valid && !bare && beat.grp_last && beat.rv_last && !or_now) |=> (dec_valid && !dec_keep));
  // R6: bare role value is kept
  a_r6_bare_keep: assert property (@(posedge clk) disable iff (rst)
    bare |=> (dec_valid && dec_keep));
  // R3: AND is preset once a decision goes out
  a_r3_preset: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> and_q);
  // R9: an invalid beat does not move the AND
  a_r9_and_hold: assert property (@(posedge clk) disable iff (rst)
    (!valid && !bare) |=> $stable(and_q));
endmodule

// File: rtl/rvs_sweep_ctr.sv
module rvs_sweep_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dec_valid,
  input  logic             dec_keep,
  input  logic             sweep_start,
  input  logic             sweep_end,
  output logic [CNT_W-1:0] drop_count,
  output logic             sweep_done,
  output logic             converged
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      drop_count <= '0;
      sweep_done <= 1'b0;
      converged  <= 1'b0;
    end else begin
      sweep_done <= sweep_end;
      if (sweep_start) begin
        drop_count <= '0;
        converged  <= 1'b0;
      end else begin
        if (dec_valid && !dec_keep && drop_count != CNT_MAX)
          drop_count <= drop_count + 1'b1;
        if (sweep_end)
          converged <= (drop_count == '0);
      end
    end
  end

  // R7: cleared at sweep start
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    sweep_start |=> (drop_count == '0));
  // R7: one step per drop below the ceiling
  a_r7_step: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_keep && !sweep_start && drop_count != CNT_MAX)
      |=> (drop_count == $past(drop_count) + 1'b1));
  // R8: convergence only after a clean sweep
  a_r8_conv: assert property (@(posedge clk) disable iff (rst)
    $rose(converged) |-> ($past(sweep_end) && $past(drop_count) == '0));
endmodule

// File: rtl/rv_support_acc.sv
module rv_support_acc
  import rvs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             res_valid,
  input  logic             res_pass,
  input  logic             res_first,
  input  logic             res_grp_last,
  input  logic             res_rv_last,
  input  logic             rv_bare,
  input  logic             sweep_start,
  input  logic             sweep_end,
  output logic             dec_valid,
  output logic             dec_keep,
  output logic [CNT_W-1:0] drop_count,
  output logic             sweep_done,
  output logic             converged
);
  beat_t beat;
  logic  or_now;

  assign beat = '{pass: res_pass, first: res_first,
                  grp_last: res_grp_last, rv_last: res_rv_last};

  rvs_group_or u_or (
    .clk(clk), .rst(rst), .valid(res_valid), .beat(beat), .or_now(or_now)
  );

  rvs_rv_and u_and (
    .clk(clk), .rst(rst), .valid(res_valid), .beat(beat), .or_now(or_now),
    .bare(rv_bare), .dec_valid(dec_valid), .dec_keep(dec_keep)
  );

  rvs_sweep_ctr #(.CNT_W(CNT_W)) u_sweep (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_keep(dec_keep),
    .sweep_start(sweep_start), .sweep_end(sweep_end),
    .drop_count(drop_count), .sweep_done(sweep_done), .converged(converged)
  );

  // R4: decision strobe lasts a single cycle when inputs are idle
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !res_valid && !rv_bare) |=> !dec_valid);
  // R8: done strobe follows a sweep close
  a_r8_done: assert property (@(posedge clk) disable iff (rst)
    sweep_end |=> sweep_done);
endmodule

// File: tb/test_rv_support_acc.sv
module test_rv_support_acc;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic res_valid = 0, res_pass = 0, res_first = 0, res_grp_last = 0, res_rv_last = 0;
  logic rv_bare = 0, sweep_start = 0, sweep_end = 0;
  logic dec_valid, dec_keep, sweep_done, converged;
  logic [CW-1:0] drop_count;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rv_support_acc #(.CNT_W(CW)) i_rv_support_acc (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_pass(res_pass),
    .res_first(res_first), .res_grp_last(res_grp_last), .res_rv_last(res_rv_last),
    .rv_bare(rv_bare), .sweep_start(sweep_start), .sweep_end(sweep_end),
    .dec_valid(dec_valid), .dec_keep(dec_keep), .drop_count(drop_count),
    .sweep_done(sweep_done), .converged(converged)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one beat for a cycle; returns at the following negedge
  task automatic beat(logic v, logic p, logic f, logic gl, logic rl);
    res_valid = v; res_pass = p; res_first = f; res_grp_last = gl; res_rv_last = rl;
    @(negedge clk);
    res_valid = 0; res_pass = 0; res_first = 0; res_grp_last = 0; res_rv_last = 0;
  endtask

  // after a final beat: check the decision, then the count one cycle later
  task automatic expect_dec(string req, int keep, int cnt);
    chk({req, " dec_valid"}, dec_valid, 1);
    chk({req, " dec_keep"}, dec_keep, keep);
    @(negedge clk);
    chk({req, " strobe width"}, dec_valid, 0);
    chk({req, " drop_count"}, drop_count, cnt);
  endtask

  task automatic t_reset;
    chk("R1 dec_valid", dec_valid, 0);
    chk("R1 dec_keep", dec_keep, 0);
    chk("R1 count", drop_count, 0);
    chk("R1 converged", converged, 0);
    chk("R1 sweep_done", sweep_done, 0);
  endtask

  task automatic t_keep_two_groups;  // R3 R4
    beat(1,0,1,0,0); beat(1,1,0,1,0);
    beat(1,1,1,1,1);
    expect_dec("R4 keep", 1, 0);
  endtask

  task automatic t_zero_group;  // R5
    beat(1,0,1,0,0); beat(1,0,0,1,0);
    beat(1,1,1,1,1);
    expect_dec("R5 zero group", 0, 1);
  endtask

  task automatic t_invalid_ignored;  // R9
    beat(1,0,1,0,0);
    beat(0,1,1,1,1);
    chk("R9 no strobe", dec_valid, 0);
    beat(1,0,0,1,1);
    expect_dec("R9 invalid ignored", 0, 2);
  endtask

  task automatic t_sticky;  // R2
    beat(1,1,1,0,0); beat(1,0,0,0,0); beat(1,0,0,1,1);
    expect_dec("R2 sticky", 1, 2);
  endtask

  task automatic t_first_restarts;  // R2 R3
    beat(1,1,1,1,0);
    beat(1,0,1,1,1);
    expect_dec("R2 first restarts", 0, 3);
    beat(1,1,1,1,1);
    expect_dec("R3 preset after drop", 1, 3);
  endtask

  task automatic t_bare;  // R6
    rv_bare = 1; @(negedge clk); rv_bare = 0;
    expect_dec("R6 bare", 1, 3);
  endtask

  task automatic t_sweeps;  // R8 R7
    sweep_end = 1; @(negedge clk); sweep_end = 0;
    chk("R8 done", sweep_done, 1);
    chk("R8 not converged", converged, 0);
    @(negedge clk);
    chk("R8 done pulse", sweep_done, 0);
    sweep_start = 1; @(negedge clk); sweep_start = 0;
    chk("R7 cleared", drop_count, 0);
    beat(1,1,1,1,1);
    expect_dec("R8 clean rv", 1, 0);
    sweep_end = 1; @(negedge clk); sweep_end = 0;
    chk("R8 converged", converged, 1);
    sweep_start = 1; @(negedge clk); sweep_start = 0;
    chk("R8 converged cleared", converged, 0);
  endtask

  task automatic t_saturate;  // R7
    for (int i = 0; i < 9; i++) begin
      beat(1,0,1,1,1);
      @(negedge clk);
    end
    chk("R7 saturates", drop_count, 7);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_keep_two_groups();
        t_zero_group();
        t_invalid_ignored();
        t_sticky();
        t_first_restarts();
        t_bare();
        t_sweeps();
        t_saturate();
      end
      begin
        repeat (5000) @(negedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule